// File: doc/BRIEF.md
# Multiplexed-Address Byte Bus Master

This block runs one single-byte read or write on a narrow parallel bus. Address and data share eight data lines. A request carries a 16-bit address, a direction, a write byte and a one-bit target select. The block sends the address as two bytes, each marked by its own latch strobe, and then sets up the data lines. For a write it drives the write byte. For a read it turns the lines around to input. It then pulls the chosen chip select low, then the read or write strobe, and waits for the target's active-low acknowledge.

A cycle counter bounds that wait. When the acknowledge arrives, or the wait expires, every strobe and chip select returns high at once and the data-line drive is released in the same cycle. A read captures the byte on the input lines. A one-cycle done pulse reports completion, with a flag that marks an expired wait. Each bus phase lasts a parameterised number of clock cycles, so that external setup and hold times are met.

Top module: `mux_bus_master`

## Requirements
- R1: After reset, and whenever `busy` is 0, both chip selects, `rdN` and `wrN` are high, both latch strobes are low and `padDataOe` is 0.
- R2: The first phase drives address bits 7:0 on `padDataOut` with `adLo` high for PHASE_CYCLES cycles. `adLo` then falls and the byte stays on the lines for another PHASE_CYCLES cycles. `adLo` pulses exactly once per transfer.
- R3: The second phase does the same with address bits 15:8 and `adHi`, and it starts after the first phase ends. The two latch strobes are never high together.
- R4: A write (`reqWrite`=1) drives the write byte with `padDataOe`=1 before the chip select falls, and keeps it driven through the strobe. A read (`reqWrite`=0) holds `padDataOe` at 0 from the end of the address phases until the transfer completes.
- R5: Target 0 pulls `csN[0]` low and target 1 pulls `csN[1]` low. The other select stays high. The select is low for PHASE_CYCLES cycles before the read or write strobe falls.
- R6: Only one of `rdN`/`wrN` falls, as the direction selects. It stays low for at least PHASE_CYCLES cycles and ends after the first cycle in which `ackN` is sampled low once that minimum has been met.
- R7: If `ackN` stays high for TIMEOUT_CYCLES strobe cycles, the transfer ends with `timeoutErr`=1. A transfer that ends on an acknowledge reports `timeoutErr`=0. The flag is valid with `done` and holds until the next completion.
- R8: The chip select and the strobe return high in the same cycle. `padDataOe` is released in that cycle too. `done` is high in that cycle only, for exactly one cycle.
- R9: On a read, `rdData` takes the value `padDataIn` had in the last strobe cycle. A write leaves `rdData` unchanged.
- R10: A `req` raised while `busy` is 1 is ignored. No second transfer starts and no extra `done` appears.
- R11: `busy` rises in the cycle after an accepted `req` and stays high until the cycle in which `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a transfer (accepted only when idle) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Transfer address |
| reqData | input | 8 | Write byte |
| reqTarget | input | 1 | Chip select to use (0 or 1) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| timeoutErr | output | 1 | Last transfer ended without acknowledge |
| rdData | output | 8 | Byte captured by the last read |
| padDataOut | output | 8 | Data line output value |
| padDataOe | output | 1 | Data line output enable |
| padDataIn | input | 8 | Data line input value |
| adLo | output | 1 | Low address byte latch strobe, active high |
| adHi | output | 1 | High address byte latch strobe, active high |
| csN | output | 2 | Chip selects, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| ackN | input | 1 | Target acknowledge, active low |

## Verification
The assertions check the invariant pin rules on every cycle. Pins are idle whenever the block is not busy, and the two latch strobes and the two bus strobes are exclusive. The data lines are never driven during a read strobe, and at most one select is low, with a select present under any strobe. The done pulse is one cycle wide, and `timeoutErr` agrees with the acknowledge level of the last strobe cycle. The bench scenarios show what spans a whole transfer: phase lengths, the address bytes seen at each latch, the minimum strobe width, the strobe length under early, late and missing acknowledges, read-data capture and the rejection of a request made while busy.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO_SET,
    ST_LO_CLR,
    ST_HI_SET,
    ST_HI_CLR,
    ST_DATA,
    ST_SEL,
    ST_STB
  } busState_t;

  typedef enum logic [1:0] {
    DSEL_ADDR_LO,
    DSEL_ADDR_HI,
    DSEL_WRITE
  } dataSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     loadReq;
    dataSel_t dataSel;
    logic     drvData;
    logic     latLo;
    logic     latHi;
    logic     chipSel;
    logic     rdStb;
    logic     wrStb;
    logic     capture;
  } ctlStrobes_t;

endpackage

// File: rtl/mbm_ctrl.sv
module mbm_ctrl
  import mbm_pkg::*;
#(
  parameter int PHASE_CYCLES   = 2,
  parameter int TIMEOUT_CYCLES = 250000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        req,
  input  logic        reqWrite,
  input  logic        ackN,
  output ctlStrobes_t ctl,
  output logic        busy,
  output logic        done,
  output logic        timeoutErr
);

  localparam int PW = $clog2(PHASE_CYCLES + 1);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [PW-1:0] PHASE_LAST = PW'(PHASE_CYCLES - 1);
  localparam logic [TW-1:0] MIN_LAST   = TW'(PHASE_CYCLES - 1);
  localparam logic [TW-1:0] WAIT_LAST  = TW'(TIMEOUT_CYCLES - 1);

  busState_t     state;
  logic [PW-1:0] phaseCnt;
  logic [TW-1:0] waitCnt;
  logic          isWrite;

  logic phaseEnd, minOk, ackSeen, expire, finish;

  assign phaseEnd = (phaseCnt == PHASE_LAST);
  assign minOk    = (waitCnt >= MIN_LAST);
  assign ackSeen  = ~ackN;
  assign expire   = (waitCnt == WAIT_LAST);
  assign finish   = (state == ST_STB) && minOk && (ackSeen || expire);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phaseCnt   <= '0;
      waitCnt    <= '0;
      isWrite    <= 1'b0;
      done       <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req) begin
            state    <= ST_LO_SET;
            phaseCnt <= '0;
            isWrite  <= reqWrite;
          end
        end
        ST_STB: begin
          if (finish) begin
            state      <= ST_IDLE;
            done       <= 1'b1;
            timeoutErr <= ~ackSeen;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        default: begin
          if (phaseEnd) begin
            phaseCnt <= '0;
            waitCnt  <= '0;
            case (state)
              ST_LO_SET: state <= ST_LO_CLR;
              ST_LO_CLR: state <= ST_HI_SET;
              ST_HI_SET: state <= ST_HI_CLR;
              ST_HI_CLR: state <= ST_DATA;
              ST_DATA:   state <= ST_SEL;
              default:   state <= ST_STB;
            endcase
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.dataSel = DSEL_WRITE;
    ctl.loadReq = (state == ST_IDLE) && req;
    case (state)
      ST_LO_SET: begin ctl.dataSel = DSEL_ADDR_LO; ctl.drvData = 1'b1; ctl.latLo = 1'b1; end
      ST_LO_CLR: begin ctl.dataSel = DSEL_ADDR_LO; ctl.drvData = 1'b1; end
      ST_HI_SET: begin ctl.dataSel = DSEL_ADDR_HI; ctl.drvData = 1'b1; ctl.latHi = 1'b1; end
      ST_HI_CLR: begin ctl.dataSel = DSEL_ADDR_HI; ctl.drvData = 1'b1; end
      ST_DATA:   ctl.drvData = isWrite;
      ST_SEL: begin ctl.drvData = isWrite; ctl.chipSel = 1'b1; end
      ST_STB: begin
        ctl.drvData = isWrite;
        ctl.chipSel = 1'b1;
        ctl.rdStb   = ~isWrite;
        ctl.wrStb   = isWrite;
        ctl.capture = finish && ~isWrite;
      end
      default: ;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/mbm_datapath.sv
module mbm_datapath
  import mbm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t ctl,
  input  logic [15:0] reqAddr,
  input  logic [7:0]  reqData,
  input  logic        reqTarget,
  input  logic [7:0]  padDataIn,
  output logic [7:0]  padDataOut,
  output logic        padDataOe,
  output logic        adLo,
  output logic        adHi,
  output logic [1:0]  csN,
  output logic        rdN,
  output logic        wrN,
  output logic [7:0]  rdData
);

  logic [15:0] addrQ;
  logic [7:0]  wrDataQ;
  logic        targetQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      wrDataQ <= '0;
      targetQ <= 1'b0;
      rdData  <= '0;
    end else begin
      if (ctl.loadReq) begin
        addrQ   <= reqAddr;
        wrDataQ <= reqData;
        targetQ <= reqTarget;
      end
      if (ctl.capture) rdData <= padDataIn;
    end
  end

  always_comb begin
    case (ctl.dataSel)
      DSEL_ADDR_LO: padDataOut = addrQ[7:0];
      DSEL_ADDR_HI: padDataOut = addrQ[15:8];
      default:      padDataOut = wrDataQ;
    endcase
  end

  assign padDataOe = ctl.drvData;
  assign adLo      = ctl.latLo;
  assign adHi      = ctl.latHi;
  assign csN       = ctl.chipSel ? (targetQ ? 2'b01 : 2'b10) : 2'b11;
  assign rdN       = ~ctl.rdStb;
  assign wrN       = ~ctl.wrStb;

endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
  import mbm_pkg::*;
#(
  parameter int PHASE_CYCLES   = 2,
  parameter int TIMEOUT_CYCLES = 250000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        req,
  input  logic        reqWrite,
  input  logic [15:0] reqAddr,
  input  logic [7:0]  reqData,
  input  logic        reqTarget,
  output logic        busy,
  output logic        done,
  output logic        timeoutErr,
  output logic [7:0]  rdData,
  output logic [7:0]  padDataOut,
  output logic        padDataOe,
  input  logic [7:0]  padDataIn,
  output logic        adLo,
  output logic        adHi,
  output logic [1:0]  csN,
  output logic        rdN,
  output logic        wrN,
  input  logic        ackN
);

  ctlStrobes_t ctl;

  mbm_ctrl #(
    .PHASE_CYCLES  (PHASE_CYCLES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .req       (req),
    .reqWrite  (reqWrite),
    .ackN      (ackN),
    .ctl       (ctl),
    .busy      (busy),
    .done      (done),
    .timeoutErr(timeoutErr)
  );

  mbm_datapath i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqAddr   (reqAddr),
    .reqData   (reqData),
    .reqTarget (reqTarget),
    .padDataIn (padDataIn),
    .padDataOut(padDataOut),
    .padDataOe (padDataOe),
    .adLo      (adLo),
    .adHi      (adHi),
    .csN       (csN),
    .rdN       (rdN),
    .wrN       (wrN),
    .rdData    (rdData)
  );

endmodule

// File: rtl/mbm_checker.sv
module mbm_checker (
  input logic       clk,
  input logic       rstN,
  input logic       req,
  input logic       busy,
  input logic       done,
  input logic       timeoutErr,
  input logic [7:0] padDataOut,
  input logic       padDataOe,
  input logic       adLo,
  input logic       adHi,
  input logic [1:0] csN,
  input logic       rdN,
  input logic       wrN,
  input logic       ackN
);

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (csN == 2'b11) && rdN && wrN && !adLo && !adHi && !padDataOe);

  assert_lo_byte_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (adLo && $past(adLo)) |-> $stable(padDataOut));

  assert_latch_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(adLo && adHi));

  assert_no_drive_on_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !padDataOe);

  assert_one_select_R5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csN) <= 1);

  assert_select_under_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !wrN) |-> (csN != 2'b11) && ($past(csN) != 2'b11));

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  assert_timeout_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && timeoutErr) |-> $past(ackN));

  assert_ack_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !timeoutErr) |-> !$past(ackN));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN == 2'b11) && rdN && wrN && !padDataOe);

  assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(req));

endmodule

bind mux_bus_master mbm_checker i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .req       (req),
  .busy      (busy),
  .done      (done),
  .timeoutErr(timeoutErr),
  .padDataOut(padDataOut),
  .padDataOe (padDataOe),
  .adLo      (adLo),
  .adHi      (adHi),
  .csN       (csN),
  .rdN       (rdN),
  .wrN       (wrN),
  .ackN      (ackN)
);

// File: tb/test_mux_bus_master.sv
module test_mux_bus_master;

  localparam int P  = 2;
  localparam int TO = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqData = '0;
  logic        reqTarget = 1'b0;
  logic        busy, done, timeoutErr;
  logic [7:0]  rdData, padDataOut;
  logic        padDataOe;
  logic [7:0]  padDataIn = '0;
  logic        adLo, adHi, rdN, wrN;
  logic [1:0]  csN;
  logic        ackN = 1'b1;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic [7:0] prevRd = '0;

  always #2 clk = ~clk;

  mux_bus_master #(.PHASE_CYCLES(P), .TIMEOUT_CYCLES(TO)) i_mux_bus_master (
    .clk(clk), .rstN(rstN), .req(req), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqData(reqData), .reqTarget(reqTarget), .busy(busy), .done(done),
    .timeoutErr(timeoutErr), .rdData(rdData), .padDataOut(padDataOut),
    .padDataOe(padDataOe), .padDataIn(padDataIn), .adLo(adLo), .adHi(adHi),
    .csN(csN), .rdN(rdN), .wrN(wrN), .ackN(ackN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expStrobe(input int ackDelay);
    if (ackDelay == 0) return TO;
    return (ackDelay > P) ? ackDelay : P;
  endfunction

  function automatic logic [1:0] expCs(input logic tgt);
    return tgt ? 2'b01 : 2'b10;
  endfunction

  // ackDelay: 0 = never acknowledge, else ack from that strobe cycle on
  task automatic transfer(input logic wr, input logic [15:0] addr, input logic [7:0] data,
                          input logic tgt, input logic [7:0] rdVal, input int ackDelay,
                          input bit pokeWhileBusy);
    int loCnt = 0, hiCnt = 0, loRises = 0, hiRises = 0, csLead = 0, stbCnt = 0;
    logic [7:0] loByte = '0, hiByte = '0, wrByte = '0;
    logic [1:0] csSeen = 2'b11;
    bit prevLo = 0, prevHi = 0, wrOeBad = 0, rdOeBad = 0, gotDone = 0, hiBeforeLo = 0;
    @(negedge clk);
    req = 1'b1; reqWrite = wr; reqAddr = addr; reqData = data; reqTarget = tgt;
    padDataIn = rdVal;
    @(negedge clk);
    req = 1'b0;
    check(busy === 1'b1, "R11 busy after req", busy, 1);
    for (int i = 0; i < 400 && !gotDone; i++) begin
      if (i == 5 && pokeWhileBusy) begin
        req = 1'b1; reqAddr = ~addr; reqWrite = ~wr;
      end else req = 1'b0;
      if (adLo) begin
        loCnt++; loByte = padDataOut;
        if (!prevLo) loRises++;
        if (hiRises != 0) hiBeforeLo = 1;
      end
      if (prevLo && !adLo) begin
        check(loCnt == P, "R2 adLo width", loCnt, P);
        check(padDataOut == loByte, "R2 low byte held", padDataOut, loByte);
      end
      if (adHi) begin
        hiCnt++; hiByte = padDataOut;
        if (!prevHi) hiRises++;
      end
      if (prevHi && !adHi) check(hiCnt == P, "R3 adHi width", hiCnt, P);
      prevLo = adLo; prevHi = adHi;
      if (csN != 2'b11) begin
        csSeen = csN;
        if (rdN && wrN) csLead++;
        if (wr && !padDataOe) wrOeBad = 1;
        if (!wr && padDataOe) rdOeBad = 1;
      end
      if (!wrN || !rdN) stbCnt++;
      if (!wrN) wrByte = padDataOut;
      if (done) begin
        gotDone = 1;
        check(loByte == addr[7:0] && loRises == 1, "R2 low address byte", loByte, addr[7:0]);
        check(hiByte == addr[15:8] && hiRises == 1 && !hiBeforeLo, "R3 high address byte",
              hiByte, addr[15:8]);
        if (wr) begin
          check(wrByte == data && !wrOeBad, "R4 write byte driven", wrByte, data);
        end else begin
          check(!rdOeBad, "R4 read turnaround", rdOeBad, 0);
        end
        check(csSeen == expCs(tgt), "R5 chip select", csSeen, expCs(tgt));
        check(csLead == P, "R5 select lead", csLead, P);
        check(stbCnt == expStrobe(ackDelay), "R6 strobe length", stbCnt, expStrobe(ackDelay));
        check(timeoutErr == (ackDelay == 0), "R7 timeout flag", timeoutErr, ackDelay == 0);
        check(csN == 2'b11 && rdN && wrN && !padDataOe && !busy, "R8 release",
              {csN, rdN, wrN, padDataOe, busy}, 6'b111100);
        if (!wr) prevRd = rdVal;
        check(rdData == prevRd, "R9 read data", rdData, prevRd);
      end
      ackN = !(((!rdN) || (!wrN)) && ackDelay > 0 && stbCnt >= ackDelay);
      if (!gotDone) @(negedge clk);
    end
    req = 1'b0;
    ackN = 1'b1;
    check(gotDone == 1, "R8 done seen", gotDone, 1);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R8 done one cycle", done, 0);
    if (pokeWhileBusy) begin
      int extra = 0;
      for (int k = 0; k < 20; k++) begin
        if (adLo || busy || done) extra++;
        @(negedge clk);
      end
      check(extra == 0, "R10 busy request ignored", extra, 0);
    end
  endtask

  initial begin
    int unused;
    unused = $urandom(32'h1234);
    repeat (3) @(negedge clk);
    check(csN == 2'b11 && rdN && wrN && !adLo && !adHi && !padDataOe && !busy && !done,
          "R1 reset idle", {csN, rdN, wrN, adLo, adHi, padDataOe}, 7'b1111000);
    rstN = 1'b1;
    @(negedge clk);
    check(csN == 2'b11 && rdN && wrN && !padDataOe && !busy, "R1 idle after reset",
          {csN, rdN, wrN, padDataOe}, 5'b11110);
    // directed corners
    transfer(1'b0, 16'h1234, 8'h00, 1'b0, 8'hA5, 1, 0);   // read, immediate ack
    transfer(1'b1, 16'hFFFF, 8'h3C, 1'b1, 8'h77, 7, 0);   // write, late ack
    transfer(1'b0, 16'h0000, 8'h00, 1'b1, 8'h5A, 0, 0);   // read timeout
    transfer(1'b1, 16'h8001, 8'hC3, 1'b0, 8'h11, 0, 0);   // write timeout
    transfer(1'b0, 16'hBEEF, 8'h00, 1'b0, 8'h99, P, 1);   // request while busy
    transfer(1'b1, 16'h00FF, 8'hF0, 1'b1, 8'h22, 3, 1);
    // random
    for (int n = 0; n < 40; n++) begin
      transfer(1'($urandom % 2), 16'($urandom), 8'($urandom), 1'($urandom % 2),
               8'($urandom), int'($urandom % 6), 0);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule